// File: doc/BRIEF.md
# Access Control Region Matcher

This block looks at each memory request and decides whether it falls inside one of a few programmable address regions. It also decides whether the request must be refused because it comes from user mode and the region is reserved for supervisor code. Every request carries an address, a flag that says whether it is an instruction fetch or a data access, and the privilege level. The block answers one cycle later with a hit flag, the number of the region that matched and an access-error flag.

There are four region registers. Regions 0 and 1 apply only to data accesses. Regions 2 and 3 apply only to instruction fetches. When several regions of the right space match, the one with the lowest number wins. When no region matches, one default-protect bit for data and one for instructions decide whether a user access is refused.

A simple write port loads the region registers and the default-protect control word. A write takes effect at the next clock edge. A request in the same cycle as a write is therefore judged against the old settings.

Top module: `region_guard`

## Requirements
- R1: After a synchronous active-low reset, every region register and the control word read as zero. `rsp_valid`, `rsp_hit`, `rsp_idx` and `rsp_err` are all zero. A request made before any write misses and raises no error.
- R2: `rsp_valid` is high exactly one cycle after a cycle with `req_valid` high, and only then. While `rsp_valid` is low, `rsp_hit`, `rsp_err` and `rsp_idx` are zero.
- R3: A region can match only if its valid bit (bit 15) is 1 and its mode field (bits 14:13) accepts the request's privilege level. The mode field accepts user only when it is 00, supervisor only when it is 01, and either level when it is 1x.
- R4: With the mask-mode bit (bit 10) at 0, a region matches when address bits 31:24 equal region bits 31:24 in every position where region bits 23:16 hold a 0.
- R5: With the mask-mode bit at 1, address bits 31:24 must equal region bits 31:24 exactly. In addition, address bits 23:20 must equal region bits 23:20 in every position where region bits 19:16 hold a 0.
- R6: Regions 0 and 1 can match only data requests (`req_instr`=0). Regions 2 and 3 can match only instruction requests (`req_instr`=1).
- R7: When more than one region of the request's space matches, `rsp_idx` reports the lowest-numbered one.
- R8: A user request that hits a region whose supervisor-protect bit (bit 3) is 1 sets `rsp_err`. A supervisor request never sets `rsp_err`.
- R9: A user data request that hits no region sets `rsp_err` exactly when control bit 23 is 1.
- R10: A user instruction request that hits no region sets `rsp_err` exactly when control bit 7 is 1.
- R11: A register write in the same cycle as a request does not affect that request. It applies from the next request onward.
- R12: The write select picks region registers with values 0 to 3 and the control word with value 4. A write with a select of 5 to 7 changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 32 | Request address |
| req_instr | input | 1 | 1 for an instruction fetch, 0 for a data access |
| req_super | input | 1 | 1 for a supervisor request, 0 for a user request |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Write target: 0 to 3 for a region, 4 for the control word |
| wr_data | input | 32 | Write data |
| rsp_valid | output | 1 | Verdict valid, one cycle after the request |
| rsp_hit | output | 1 | A region matched |
| rsp_idx | output | 2 | Number of the winning region (0 on a miss) |
| rsp_err | output | 1 | Access refused |

## Verification
The bound checker watches several properties on every cycle:
- the one-cycle response timing;
- the quiet outputs between responses;
- that supervisor requests are never refused;
- that a reported region index always belongs to the space of the request;
- that a refusal on a miss comes only from a user request.

Other behaviours only show up in the bench's scenarios, where a scoreboard compares every response with a model of the programmed registers:
- the exact address comparison in both mask modes;
- the mode-field decode;
- lowest-index priority;
- which default bit applies on a miss;
- the same-cycle write ordering;
- the ignored write selects.

// File: rtl/region_guard_pkg.sv
// Package: shared field positions and the decoded region type for the
// access control region matcher. Assumes 32-bit addresses and register words.
package region_guard_pkg;

    localparam int unsigned WORD_W     = 32;
    localparam int unsigned BASE_HI    = 31;
    localparam int unsigned BASE_LO    = 24;
    localparam int unsigned MASK_HI    = 23;
    localparam int unsigned MASK_LO    = 16;
    localparam int unsigned VALID_BIT  = 15;
    localparam int unsigned MODE_HI    = 14;
    localparam int unsigned MODE_LO    = 13;
    localparam int unsigned FINE_BIT   = 10;
    localparam int unsigned SPROT_BIT  = 3;
    localparam int unsigned DDEF_BIT   = 23;
    localparam int unsigned IDEF_BIT   = 7;

    // Decoded contents of one region register.
    typedef struct packed {
        logic [7:0] base;
        logic [7:0] mask;
        logic       valid;
        logic [1:0] mode;
        logic       fine;
        logic       sprot;
    } region_cfg_t;

    // Control word fields that matter to the verdict.
    typedef struct packed {
        logic dflt_data;
        logic dflt_instr;
    } ctrl_cfg_t;

    // Pull the meaningful fields out of a written word.
    function automatic region_cfg_t unpack_region(input logic [WORD_W-1:0] w);
        region_cfg_t r;
        r.base  = w[BASE_HI:BASE_LO];
        r.mask  = w[MASK_HI:MASK_LO];
        r.valid = w[VALID_BIT];
        r.mode  = w[MODE_HI:MODE_LO];
        r.fine  = w[FINE_BIT];
        r.sprot = w[SPROT_BIT];
        return r;
    endfunction

endpackage

// File: rtl/rg_cfg_regs.sv
// Module: rg_cfg_regs
// Holds the region registers and the default-protect control word.
// Assumes one write per cycle; select values above NUM_REGIONS are ignored.
module rg_cfg_regs
    import region_guard_pkg::*;
#(
    parameter int unsigned NUM_REGIONS = 4,
    localparam int unsigned SEL_W      = $clog2(NUM_REGIONS + 1)
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [SEL_W-1:0]                   wr_sel,
    input  logic [WORD_W-1:0]                  wr_data,
    output region_cfg_t [NUM_REGIONS-1:0]      region_q,
    output ctrl_cfg_t                          ctrl_q
);

    localparam logic [SEL_W-1:0] CTRL_SEL = SEL_W'(NUM_REGIONS);

    // Bits of the write word that no register keeps.
    logic unused_wr_bits;
    assign unused_wr_bits = ^{wr_data[12:11], wr_data[9:8], wr_data[6:4], wr_data[2:0]};

    genvar gi;
    generate
        for (gi = 0; gi < NUM_REGIONS; gi++) begin : g_region
            localparam logic [SEL_W-1:0] MY_SEL = SEL_W'(gi);
            // Load one region register when it is selected.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    region_q[gi] <= '0;
                end else if (wr_en && (wr_sel == MY_SEL)) begin
                    region_q[gi] <= unpack_region(wr_data);
                end
            end
        end
    endgenerate

    // Load the control word when it is selected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_en && (wr_sel == CTRL_SEL)) begin
            ctrl_q.dflt_data  <= wr_data[DDEF_BIT];
            ctrl_q.dflt_instr <= wr_data[IDEF_BIT];
        end
    end

endmodule

// File: rtl/rg_region_match.sv
// Module: rg_region_match
// Decides, without a clock, whether one region accepts a request. It checks
// the valid bit, the privilege mode and the address in either mask mode.
// Assumes only address bits 31:20 take part in the comparison.
module rg_region_match
    import region_guard_pkg::*;
(
    input  region_cfg_t cfg,
    input  logic [11:0] addr_hi,
    input  logic        req_super,
    output logic        match
);

    logic       mode_ok;
    logic       coarse_ok;
    logic       fine_ok;
    logic [7:0] top_byte;
    logic [3:0] nibble;

    assign top_byte = addr_hi[11:4];
    assign nibble   = addr_hi[3:0];

    // Mode field: 1x accepts either level, otherwise bit 0 names the level.
    always_comb begin
        mode_ok = cfg.mode[1] | (cfg.mode[0] == req_super);
    end

    // Address comparison for both mask modes.
    always_comb begin
        coarse_ok = ((top_byte ^ cfg.base) & ~cfg.mask) == 8'h00;
        fine_ok   = (top_byte == cfg.base) &&
                    (((nibble ^ cfg.mask[7:4]) & ~cfg.mask[3:0]) == 4'h0);
    end

    // Combine validity, mode and the selected address test.
    always_comb begin
        match = cfg.valid && mode_ok && (cfg.fine ? fine_ok : coarse_ok);
    end

endmodule

// File: rtl/rg_verdict.sv
// Module: rg_verdict
// Filters the region matches by address space, picks the lowest index and
// decides the protection verdict. It registers the result one cycle after
// the request. Assumes regions below DATA_REGIONS serve data and the rest
// serve instructions.
module rg_verdict
    import region_guard_pkg::*;
#(
    parameter int unsigned NUM_REGIONS  = 4,
    parameter int unsigned DATA_REGIONS = 2,
    localparam int unsigned IDX_W       = $clog2(NUM_REGIONS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic                   req_instr,
    input  logic                   req_super,
    input  logic [NUM_REGIONS-1:0] match,
    input  logic [NUM_REGIONS-1:0] sprot,
    input  ctrl_cfg_t              ctrl,
    output logic                   rsp_valid,
    output logic                   rsp_hit,
    output logic [IDX_W-1:0]       rsp_idx,
    output logic                   rsp_err
);

    logic [NUM_REGIONS-1:0] cand;
    logic                   pick_hit;
    logic [IDX_W-1:0]       pick_idx;
    logic                   pick_err;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_REGIONS; gi++) begin : g_space
            localparam bit IS_INSTR = (gi >= DATA_REGIONS);
            assign cand[gi] = match[gi] && (IS_INSTR == req_instr);
        end
    endgenerate

    // Lowest-numbered candidate wins: scan downward so the last write is the lowest.
    always_comb begin
        pick_hit = 1'b0;
        pick_idx = '0;
        for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
            if (cand[i]) begin
                pick_hit = 1'b1;
                pick_idx = IDX_W'(i);
            end
        end
    end

    // Protection verdict: supervisor always passes, user checks region or default.
    always_comb begin
        if (req_super) begin
            pick_err = 1'b0;
        end else if (pick_hit) begin
            pick_err = sprot[pick_idx];
        end else begin
            pick_err = req_instr ? ctrl.dflt_instr : ctrl.dflt_data;
        end
    end

    // Register the verdict; outputs stay zero between responses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_idx   <= '0;
            rsp_err   <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            rsp_hit   <= req_valid && pick_hit;
            rsp_idx   <= req_valid ? pick_idx : '0;
            rsp_err   <= req_valid && pick_err;
        end
    end

endmodule

// File: rtl/region_guard.sv
// Module: region_guard (top)
// Access control region matcher. It checks each request against the region
// registers and reports hit, region index and access error one cycle later.
// Assumes 32-bit addresses; a write and a request in one cycle see old values.
module region_guard
    import region_guard_pkg::*;
#(
    parameter int unsigned NUM_REGIONS  = 4,
    parameter int unsigned DATA_REGIONS = 2,
    localparam int unsigned IDX_W       = $clog2(NUM_REGIONS),
    localparam int unsigned SEL_W       = $clog2(NUM_REGIONS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [WORD_W-1:0] req_addr,
    input  logic              req_instr,
    input  logic              req_super,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [IDX_W-1:0]  rsp_idx,
    output logic              rsp_err
);

    region_cfg_t [NUM_REGIONS-1:0] region_q;
    ctrl_cfg_t                     ctrl_q;
    logic [NUM_REGIONS-1:0]        match;
    logic [NUM_REGIONS-1:0]        sprot;

    // Low address bits lie inside every region and are not compared.
    logic unused_addr_bits;
    assign unused_addr_bits = ^req_addr[19:0];

    rg_cfg_regs #(
        .NUM_REGIONS(NUM_REGIONS)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .region_q (region_q),
        .ctrl_q   (ctrl_q)
    );

    genvar gi;
    generate
        for (gi = 0; gi < NUM_REGIONS; gi++) begin : g_match
            rg_region_match u_match (
                .cfg       (region_q[gi]),
                .addr_hi   (req_addr[31:20]),
                .req_super (req_super),
                .match     (match[gi])
            );
            assign sprot[gi] = region_q[gi].sprot;
        end
    endgenerate

    rg_verdict #(
        .NUM_REGIONS (NUM_REGIONS),
        .DATA_REGIONS(DATA_REGIONS)
    ) u_verdict (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_instr (req_instr),
        .req_super (req_super),
        .match     (match),
        .sprot     (sprot),
        .ctrl      (ctrl_q),
        .rsp_valid (rsp_valid),
        .rsp_hit   (rsp_hit),
        .rsp_idx   (rsp_idx),
        .rsp_err   (rsp_err)
    );

endmodule

// File: rtl/region_guard_chk.sv
// Module: region_guard_chk
// Property checker for region_guard, attached through bind. It watches
// response timing, quiet idle outputs, space of the index and the rules
// for a refusal.
module region_guard_chk #(
    parameter int unsigned NUM_REGIONS  = 4,
    parameter int unsigned DATA_REGIONS = 2,
    localparam int unsigned IDX_W       = $clog2(NUM_REGIONS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_instr,
    input logic             req_super,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic [IDX_W-1:0] rsp_idx,
    input logic             rsp_err
);

    localparam logic [IDX_W-1:0] FIRST_INSTR = IDX_W'(DATA_REGIONS);

    p_resp_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_hit && !rsp_err && rsp_idx == '0));

    p_super_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_super) |=> !rsp_err);

    p_instr_space_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_instr) |=> (!rsp_hit || rsp_idx >= FIRST_INSTR));

    p_data_space_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_instr) |=> (!rsp_hit || rsp_idx < FIRST_INSTR));

    // R9 and R10: a refusal on a miss needs a user request.
    p_miss_err_user_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_super) |=> !(rsp_valid && !rsp_hit && rsp_err));

endmodule

bind region_guard region_guard_chk #(
    .NUM_REGIONS (NUM_REGIONS),
    .DATA_REGIONS(DATA_REGIONS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_instr (req_instr),
    .req_super (req_super),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_idx   (rsp_idx),
    .rsp_err   (rsp_err)
);

// File: tb/tb_region_guard.sv
// Scoreboard bench for region_guard: the driver tasks push the expected
// verdicts taken from a shadow model of the registers; the monitor pops
// and compares them.
module tb_region_guard;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_instr = 1'b0;
    logic        req_super = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic        rsp_valid;
    logic        rsp_hit;
    logic [1:0]  rsp_idx;
    logic        rsp_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic       hit;
        logic [1:0] idx;
        logic       err;
        string      tag;
    } exp_t;

    exp_t        sb[$];
    logic [31:0] sh_reg [4];
    logic [31:0] sh_ctrl;

    always #5 clk = ~clk;

    region_guard dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_instr(req_instr), .req_super(req_super), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_idx(rsp_idx), .rsp_err(rsp_err)
    );

    function automatic logic [31:0] mk(input logic [7:0] base, input logic [7:0] mask,
                                       input logic vld, input logic [1:0] mode,
                                       input logic fine, input logic sp);
        return {base, mask, vld, mode, 2'b00, fine, 6'b0, sp, 3'b000};
    endfunction

    function automatic exp_t model(input logic [31:0] a, input logic ins, input logic sup);
        exp_t e;
        e.hit = 1'b0;
        e.idx = 2'd0;
        for (int i = 0; i < 4; i++) begin
            logic [31:0] r;
            logic        ok;
            r = sh_reg[i];
            if (r[10])
                ok = (a[31:24] == r[31:24]) &&
                     ((a[23:20] & ~r[19:16]) == (r[23:20] & ~r[19:16]));
            else
                ok = ((a[31:24] & ~r[23:16]) == (r[31:24] & ~r[23:16]));
            ok = ok && r[15] && (r[14] || (r[13] == sup)) && ((i >= 2) == ins);
            if (ok && !e.hit) begin
                e.hit = 1'b1;
                e.idx = 2'(i);
            end
        end
        if (sup) e.err = 1'b0;
        else if (e.hit) e.err = sh_reg[e.idx][3];
        else e.err = ins ? sh_ctrl[7] : sh_ctrl[23];
        return e;
    endfunction

    task automatic shadow_write(input logic [2:0] sel, input logic [31:0] d);
        if (sel < 3'd4) sh_reg[sel[1:0]] = d;
        else if (sel == 3'd4) sh_ctrl = d;
    endtask

    task automatic cfg_write(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        shadow_write(sel, d);
    endtask

    task automatic send(input logic [31:0] a, input logic ins, input logic sup, input string tag);
        exp_t e;
        @(negedge clk);
        e = model(a, ins, sup);
        e.tag = tag;
        sb.push_back(e);
        req_valid = 1'b1; req_addr = a; req_instr = ins; req_super = sup;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Request and write in the same cycle: the verdict uses the old settings.
    task automatic send_with_write(input logic [31:0] a, input logic ins, input logic sup,
                                   input logic [2:0] sel, input logic [31:0] d, input string tag);
        exp_t e;
        @(negedge clk);
        e = model(a, ins, sup);
        e.tag = tag;
        sb.push_back(e);
        req_valid = 1'b1; req_addr = a; req_instr = ins; req_super = sup;
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        req_valid = 1'b0; wr_en = 1'b0;
        shadow_write(sel, d);
    endtask

    // Monitor: compare each response with the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            checks++;
            if (sb.size() == 0) begin
                errors++;
                $display("FAIL R2: response with nothing expected, actual hit=%0b idx=%0d err=%0b expected none",
                         rsp_hit, rsp_idx, rsp_err);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (rsp_hit !== e.hit || rsp_idx !== e.idx || rsp_err !== e.err) begin
                    errors++;
                    $display("FAIL %s: actual hit=%0b idx=%0d err=%0b expected hit=%0b idx=%0d err=%0b",
                             e.tag, rsp_hit, rsp_idx, rsp_err, e.hit, e.idx, e.err);
                end
            end
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) sh_reg[i] = '0;
        sh_ctrl = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0 || rsp_hit !== 1'b0 || rsp_idx !== 2'd0 || rsp_err !== 1'b0) begin
            errors++;
            $display("FAIL R1: actual valid=%0b hit=%0b idx=%0d err=%0b expected all zero",
                     rsp_valid, rsp_hit, rsp_idx, rsp_err);
        end
        send(32'h4000_0000, 1'b0, 1'b0, "R1");
        send(32'h4000_0000, 1'b1, 1'b0, "R1");

        // R4: coarse mode
        cfg_write(3'd0, mk(8'h40, 8'h00, 1'b1, 2'b10, 1'b0, 1'b0));
        send(32'h4012_3456, 1'b0, 1'b0, "R4");
        send(32'h4100_0000, 1'b0, 1'b0, "R4");
        cfg_write(3'd0, mk(8'h40, 8'h03, 1'b1, 2'b10, 1'b0, 1'b0));
        send(32'h43AB_CDEF, 1'b0, 1'b0, "R4");
        send(32'h4400_0000, 1'b0, 1'b0, "R4");

        // R5: fine mode, nibble 5 with bit 0 masked
        cfg_write(3'd1, mk(8'h80, 8'h51, 1'b1, 2'b10, 1'b1, 1'b0));
        send(32'h8051_2345, 1'b0, 1'b0, "R5");
        send(32'h8040_0000, 1'b0, 1'b0, "R5");
        send(32'h8060_0000, 1'b0, 1'b0, "R5");
        send(32'h8150_0000, 1'b0, 1'b0, "R5");

        // R6: space separation
        send(32'h4000_0000, 1'b1, 1'b0, "R6");
        cfg_write(3'd2, mk(8'h40, 8'h00, 1'b1, 2'b10, 1'b0, 1'b0));
        send(32'h4000_0000, 1'b1, 1'b0, "R6");
        cfg_write(3'd3, mk(8'h40, 8'h00, 1'b1, 2'b10, 1'b0, 1'b0));
        send(32'h4000_0000, 1'b1, 1'b1, "R7");

        // R7: lowest index wins; R3: invalid region ignored
        cfg_write(3'd1, mk(8'h40, 8'h00, 1'b1, 2'b10, 1'b0, 1'b0));
        send(32'h4000_0000, 1'b0, 1'b0, "R7");
        cfg_write(3'd0, mk(8'h40, 8'h00, 1'b0, 2'b10, 1'b0, 1'b0));
        send(32'h4000_0000, 1'b0, 1'b0, "R3");

        // R3: mode field
        cfg_write(3'd1, mk(8'h40, 8'h00, 1'b1, 2'b00, 1'b0, 1'b0));
        send(32'h4000_0000, 1'b0, 1'b0, "R3");
        send(32'h4000_0000, 1'b0, 1'b1, "R3");
        cfg_write(3'd1, mk(8'h40, 8'h00, 1'b1, 2'b01, 1'b0, 1'b0));
        send(32'h4000_0000, 1'b0, 1'b0, "R3");
        send(32'h4000_0000, 1'b0, 1'b1, "R3");
        cfg_write(3'd1, mk(8'h40, 8'h00, 1'b1, 2'b11, 1'b0, 1'b0));
        send(32'h4000_0000, 1'b0, 1'b0, "R3");
        send(32'h4000_0000, 1'b0, 1'b1, "R3");

        // R8: supervisor protect on a region
        cfg_write(3'd1, mk(8'h40, 8'h00, 1'b1, 2'b11, 1'b0, 1'b1));
        send(32'h4000_0000, 1'b0, 1'b0, "R8");
        send(32'h4000_0000, 1'b0, 1'b1, "R8");

        // R9: data default protect
        cfg_write(3'd4, 32'h0080_0000);
        send(32'h1000_0000, 1'b0, 1'b0, "R9");
        send(32'h1000_0000, 1'b0, 1'b1, "R9");
        send(32'h1000_0000, 1'b1, 1'b0, "R10");

        // R10: instruction default protect
        cfg_write(3'd4, 32'h0000_0080);
        send(32'h1000_0000, 1'b1, 1'b0, "R10");
        send(32'h1000_0000, 1'b0, 1'b0, "R10");

        // R11: same-cycle write sees old settings
        send_with_write(32'h1000_0000, 1'b1, 1'b0, 3'd4, 32'h0, "R11");
        send(32'h1000_0000, 1'b1, 1'b0, "R11");

        // R12: unused selects change nothing
        cfg_write(3'd5, 32'hFFFF_FFFF);
        cfg_write(3'd7, 32'hFFFF_FFFF);
        send(32'h1000_0000, 1'b1, 1'b0, "R12");
        send(32'h4000_0000, 1'b0, 1'b0, "R12");

        repeat (3) @(negedge clk);
        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R2: actual %0d responses missing expected 0", sb.size());
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R2: watchdog expired, actual running expected finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule